// File: doc/BRIEF.md
# Spare-Column Programmable AND-OR Array

This block is a two-level sum-of-products fabric. Each primary input produces two literal rows, its true value and its complement. A configuration bit sits at every crossing of a literal row and a product-term column. A set bit ties the literal into the column's AND. A clear bit leaves that AND input at logic 1. The columns are split into equal groups, and each group's columns are ORed into one output. The last columns of every group are spares. They are ORed into that group's output in the same way as the normal columns. A column whose term is faulty can therefore be retired and rebuilt on a spare of the same group.

For test and repair experiments, every crossing also holds two fault-injection mask bits. One forces the crossing on and the other forces it off, whatever its programmed bit. Configuration and fault masks are written one whole column at a time on a clock edge. The raw column outputs are brought out next to the group outputs, so a diagnosis routine can see each term. There is no control sequencing in this block, so there is no state machine. Its only state is the per-column storage, and that storage loads only when it is addressed.

Top module: `sca_array`

## Requirements
- R1: While reset is low and afterwards until the first write, all configuration bits and fault masks are zero. Every column output and every group output is therefore 1.
- R2: Literal row 2*i carries in_vec[i] and row 2*i+1 carries its complement. Bit r of a column's configuration word belongs to row r. An ON cross-point (bit = 1) ANDs its row literal into the column.
- R3: An OFF cross-point (bit = 0) puts logic 1 on its AND input, so a column with no ON cross-point outputs 1.
- R4: Column c belongs to group c / (N_NORM+N_SPARE). Positions N_NORM and above within a group are spares. Each group output is the OR of all its columns, spares included.
- R5: A column affects only the output of its own group.
- R6: A column with both literals of one input ON outputs 0 for every input value, which makes it neutral in its group.
- R7: A set force_on mask bit makes its cross-point act as ON even when it is programmed OFF. Setting force_on and force_off on the same cross-point is not allowed.
- R8: A set force_off mask bit makes its cross-point act as OFF even when it is programmed ON.
- R9: With flt_we high, both mask words of column flt_col are replaced at the next rising edge. Writing zero masks restores the programmed behaviour.
- R10: With cfg_we high, the configuration word of column cfg_col is replaced by cfg_data at the next rising edge and not earlier. A write to a column index at or above the column count changes nothing.
- R11: Column and group outputs follow in_vec combinationally, within the same cycle.
- R12: With no write and steady inputs, every column output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration and mask writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vec | input | N_IN (16) | Primary inputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_col | input | COL_W (7) | Column addressed by a configuration write |
| cfg_data | input | ROWS (32) | New configuration word, bit r for literal row r |
| flt_we | input | 1 | Fault-mask write enable |
| flt_col | input | COL_W (7) | Column addressed by a fault-mask write |
| flt_on | input | ROWS (32) | Force-on mask word |
| flt_off | input | ROWS (32) | Force-off mask word |
| col_out | output | N_COL (80) | Raw product-term outputs |
| grp_out | output | N_GRP (8) | ORed group outputs |

## Verification
The outputs depend on in_vec through logic alone. A change that the bench applies at a falling edge is therefore checked 1 ns later, with no clock edge in between. A configuration or mask write is driven at a falling edge and takes effect at the next rising edge. It is checked once just before that edge to show it has not yet applied, and again after the edge to show it has. The remaining checks run after the falling edge that follows the write, well clear of the rising edge.

// File: rtl/sca_pkg.sv
package sca_pkg;
    // Row index of the literal for input v: even rows true, odd rows complement (R2)
    function automatic int unsigned lit_index(input int unsigned v, input bit comp);
        return 2 * v + (comp ? 1 : 0);
    endfunction
endpackage

// File: rtl/sca_literals.sv
module sca_literals
    import sca_pkg::*;
#(
    parameter int N_IN = 16
) (
    input  logic [N_IN-1:0]   in_vec,
    output logic [2*N_IN-1:0] lits
);
    for (genvar v = 0; v < N_IN; v++) begin : g_lit
        assign lits[lit_index(v, 1'b0)] = in_vec[v];
        assign lits[lit_index(v, 1'b1)] = ~in_vec[v];
    end
endmodule

// File: rtl/sca_column.sv
module sca_column #(
    parameter int ROWS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_hit,
    input  logic [ROWS-1:0] cfg_data,
    input  logic            flt_hit,
    input  logic [ROWS-1:0] flt_on,
    input  logic [ROWS-1:0] flt_off,
    input  logic [ROWS-1:0] lits,
    output logic            prod
);
    logic [ROWS-1:0] prog_q;
    logic [ROWS-1:0] on_q;
    logic [ROWS-1:0] off_q;
    logic [ROWS-1:0] eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
            on_q   <= '0;
            off_q  <= '0;
        end else begin
            if (cfg_hit) begin
                prog_q <= cfg_data;
            end
            if (flt_hit) begin
                on_q  <= flt_on;
                off_q <= flt_off;
            end
        end
    end

    // Effective connection after fault masks; an unconnected input reads 1
    always_comb begin
        eff  = (prog_q | on_q) & ~off_q;
        prod = &(lits | ~eff);
    end
endmodule

// File: rtl/sca_group_or.sv
module sca_group_or #(
    parameter int W = 10
) (
    input  logic [W-1:0] cols,
    output logic         y
);
    assign y = |cols;
endmodule

// File: rtl/sca_array.sv
module sca_array #(
    parameter int N_IN    = 16,
    parameter int N_GRP   = 8,
    parameter int N_NORM  = 8,
    parameter int N_SPARE = 2,
    localparam int ROWS   = 2 * N_IN,
    localparam int CPG    = N_NORM + N_SPARE,
    localparam int N_COL  = N_GRP * CPG,
    localparam int COL_W  = $clog2(N_COL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_vec,
    input  logic             cfg_we,
    input  logic [COL_W-1:0] cfg_col,
    input  logic [ROWS-1:0]  cfg_data,
    input  logic             flt_we,
    input  logic [COL_W-1:0] flt_col,
    input  logic [ROWS-1:0]  flt_on,
    input  logic [ROWS-1:0]  flt_off,
    output logic [N_COL-1:0] col_out,
    output logic [N_GRP-1:0] grp_out
);
    logic [ROWS-1:0] lits;

    sca_literals #(.N_IN(N_IN)) u_lits (
        .in_vec (in_vec),
        .lits   (lits)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        logic cfg_hit;
        logic flt_hit;
        assign cfg_hit = cfg_we && (cfg_col == COL_W'(c));
        assign flt_hit = flt_we && (flt_col == COL_W'(c));

        sca_column #(.ROWS(ROWS)) u_col (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (cfg_hit),
            .cfg_data (cfg_data),
            .flt_hit  (flt_hit),
            .flt_on   (flt_on),
            .flt_off  (flt_off),
            .lits     (lits),
            .prod     (col_out[c])
        );
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        sca_group_or #(.W(CPG)) u_or (
            .cols (col_out[g*CPG +: CPG]),
            .y    (grp_out[g])
        );
    end
endmodule

// File: rtl/sca_array_chk.sv
module sca_array_chk #(
    parameter int N_IN  = 16,
    parameter int N_GRP = 8,
    parameter int CPG   = 10,
    parameter int ROWS  = 32,
    parameter int N_COL = 80
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_vec,
    input logic             cfg_we,
    input logic             flt_we,
    input logic [ROWS-1:0]  flt_on,
    input logic [ROWS-1:0]  flt_off,
    input logic [N_COL-1:0] col_out,
    input logic [N_GRP-1:0] grp_out
);
    AST_RESET_ALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((&col_out) && (&grp_out))); // R1

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_we |-> ((flt_on & flt_off) == '0)); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && !$past(flt_we) && $stable(in_vec)) |-> $stable(col_out)); // R12

    for (genvar g = 0; g < N_GRP; g++) begin : g_chk
        AST_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_out[g] |-> (col_out[g*CPG +: CPG] == '0)); // R4
        AST_GROUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (col_out[g*CPG +: CPG] != '0) |-> grp_out[g]); // R5
    end
endmodule

bind sca_array sca_array_chk #(
    .N_IN  (N_IN),
    .N_GRP (N_GRP),
    .CPG   (CPG),
    .ROWS  (ROWS),
    .N_COL (N_COL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vec  (in_vec),
    .cfg_we  (cfg_we),
    .flt_we  (flt_we),
    .flt_on  (flt_on),
    .flt_off (flt_off),
    .col_out (col_out),
    .grp_out (grp_out)
);

// File: tb/tb_sca_array.sv
`timescale 1ns/1ps
module tb_sca_array;
    localparam int N_IN  = 16;
    localparam int N_GRP = 8;
    localparam int N_COL = 80;
    localparam int ROWS  = 32;
    localparam int COL_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  in_vec = '0;
    logic             cfg_we = 1'b0;
    logic [COL_W-1:0] cfg_col = '0;
    logic [ROWS-1:0]  cfg_data = '0;
    logic             flt_we = 1'b0;
    logic [COL_W-1:0] flt_col = '0;
    logic [ROWS-1:0]  flt_on = '0;
    logic [ROWS-1:0]  flt_off = '0;
    logic [N_COL-1:0] col_out;
    logic [N_GRP-1:0] grp_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sca_array dut (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
        .cfg_we(cfg_we), .cfg_col(cfg_col), .cfg_data(cfg_data),
        .flt_we(flt_we), .flt_col(flt_col), .flt_on(flt_on), .flt_off(flt_off),
        .col_out(col_out), .grp_out(grp_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input int col, input logic [ROWS-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_col = COL_W'(col); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_flt(input int col, input logic [ROWS-1:0] on_m, input logic [ROWS-1:0] off_m);
        @(negedge clk);
        flt_we = 1'b1; flt_col = COL_W'(col); flt_on = on_m; flt_off = off_m;
        @(negedge clk);
        flt_we = 1'b0; flt_on = '0; flt_off = '0;
    endtask

    task automatic set_in(input logic [N_IN-1:0] v);
        in_vec = v;
        #1;
    endtask

    task automatic t_reset;
        set_in(16'h1234);
        chk("R1", "col_out all ones", 128'(col_out), 128'({N_COL{1'b1}}));
        chk("R1", "grp_out all ones", 128'(grp_out), 128'(8'hFF));
    endtask

    task automatic t_neutral_all;
        for (int c = 0; c < N_COL; c++) wr_cfg(c, 32'h3);
        set_in(16'h0000);
        chk("R6", "all neutral cols in=0", 128'(col_out), 128'(0));
        set_in(16'h0001);
        chk("R6", "all neutral grps in=1", 128'(grp_out), 128'(0));
    endtask

    task automatic t_literals;
        wr_cfg(0, 32'h9); // x0 & ~x1
        set_in(16'h0001); chk("R2", "x0&~x1 in=01", 128'(col_out[0]), 128'(1));
        chk("R2", "grp0 in=01", 128'(grp_out[0]), 128'(1));
        set_in(16'h0003); chk("R2", "x0&~x1 in=11", 128'(col_out[0]), 128'(0));
        set_in(16'h0000); chk("R2", "x0&~x1 in=00", 128'(col_out[0]), 128'(0));
        set_in(16'h0002); chk("R2", "x0&~x1 in=10", 128'(col_out[0]), 128'(0));
        wr_cfg(1, 32'h0);
        chk("R3", "empty column", 128'(col_out[1]), 128'(1));
        chk("R3", "grp0 with empty column", 128'(grp_out[0]), 128'(1));
        wr_cfg(1, 32'h3);
        wr_cfg(0, 32'h3);
    endtask

    task automatic t_spare;
        wr_cfg(8, 32'h10); // first spare of group 0: x2
        set_in(16'h0004); chk("R4", "spare col8 drives grp0", 128'(grp_out[0]), 128'(1));
        set_in(16'h0000); chk("R4", "spare col8 low", 128'(grp_out[0]), 128'(0));
        wr_cfg(8, 32'h3);
        wr_cfg(9, 32'h100); // last spare of group 0: x4
        set_in(16'h0010); chk("R4", "spare col9 drives grp0", 128'(grp_out), 128'(8'h01));
        wr_cfg(9, 32'h3);
    endtask

    task automatic t_isolation;
        wr_cfg(10, 32'h10); // group 1 col 0: x2
        set_in(16'h0004);
        chk("R5", "only grp1 high", 128'(grp_out), 128'(8'h02));
        chk("R5", "col10 alone high", 128'(col_out), 128'(80'h1 << 10));
    endtask

    task automatic t_neutral;
        wr_cfg(10, 32'h30); // x2 & ~x2
        set_in(16'h0004); chk("R6", "pair in=4", 128'(col_out[10]), 128'(0));
        set_in(16'h0000); chk("R6", "pair in=0", 128'(col_out[10]), 128'(0));
    endtask

    task automatic t_stuck_on;
        wr_cfg(20, 32'h100); // x4
        set_in(16'h0010); chk("R7", "col20 before fault", 128'(col_out[20]), 128'(1));
        wr_flt(20, 32'h200, 32'h0); // ~x4 forced on
        chk("R7", "col20 forced on in=16", 128'(col_out[20]), 128'(0));
        set_in(16'h0000); chk("R7", "col20 forced on in=0", 128'(col_out[20]), 128'(0));
        chk("R7", "grp2 low", 128'(grp_out[2]), 128'(0));
    endtask

    task automatic t_stuck_off;
        wr_flt(21, 32'h0, 32'h2); // ~x0 forced off, col21 programmed x0&~x0
        set_in(16'h0001); chk("R8", "col21 forced off in=1", 128'(col_out[21]), 128'(1));
        set_in(16'h0000); chk("R8", "col21 forced off in=0", 128'(col_out[21]), 128'(0));
        wr_flt(21, 32'h0, 32'h0);
        set_in(16'h0001); chk("R9", "col21 masks cleared", 128'(col_out[21]), 128'(0));
    endtask

    task automatic t_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_col = 7'd30; cfg_data = 32'h0;
        #1 chk("R10", "col30 before edge", 128'(col_out[30]), 128'(0));
        @(posedge clk);
        #1 chk("R10", "col30 after edge", 128'(col_out[30]), 128'(1));
        @(negedge clk);
        cfg_we = 1'b0;
        wr_cfg(30, 32'h3);
    endtask

    task automatic t_comb;
        wr_cfg(31, 32'h4); // x1
        set_in(16'h0002); chk("R11", "col31 in=2", 128'(col_out[31]), 128'(1));
        chk("R11", "grp3 in=2", 128'(grp_out[3]), 128'(1));
        set_in(16'h0000); chk("R11", "col31 in=0", 128'(col_out[31]), 128'(0));
        chk("R11", "grp3 in=0", 128'(grp_out[3]), 128'(0));
        set_in(16'h0002);
    endtask

    task automatic t_hold_oob;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R12", "col_out held", 128'(col_out), 128'(80'h1 << 31));
        chk("R12", "grp_out held", 128'(grp_out), 128'(8'h08));
        wr_cfg(127, 32'h0);
        chk("R10", "out of range write ignored", 128'(col_out), 128'(80'h1 << 31));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_neutral_all;
        t_literals;
        t_spare;
        t_isolation;
        t_neutral;
        t_stuck_on;
        t_stuck_off;
        t_timing;
        t_comb;
        t_hold_oob;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule